// File: doc/BRIEF.md
# Radio MAC Interrupt and Transmit-Trigger Controller

This block is the host-facing control unit of a packet radio MAC. A host on a byte-wide register bus starts a frame from the normal transmit buffer by setting a trigger bit. It can also ask for the frame to be acknowledged. The host then waits on a level-sensitive, active-low interrupt and reads status to learn whether the frame went out or failed after too many retries.

A modelled MAC engine sends three kinds of event back to the block, each a one-cycle pulse: transmit accepted, frame sent (with a retry-failure qualifier) and frame received. Frame events set sticky flags. A read of the flag register clears them. A mask register can hold each interrupt source off, and a mask bit of 1 disables its source.

Register reads are combinational: `reg_rdata` is valid in the same cycle as `reg_rd`. Side effects of a read or write take place at the next rising clock edge.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset, `tx_req` and `tx_ack_req` are 0 and `irq_n` is 1. Reads return 0x00 from address 0x1B, 0x00 from 0x24, 0x00 from 0x31 and 0x09 from 0x32, so both interrupt sources start masked.
- R2: A write to address 0x1B with bit 0 set raises `tx_req` after the next clock edge. While it is pending, a read of 0x1B returns 1 in bit 0.
- R3: Every write to 0x1B stores bit 2 as the acknowledgement request. It drives `tx_ack_req` and reads back in bit 2 of 0x1B.
- R4: A pending `tx_req` stays at 1 until `mac_tx_accept` is sampled, and it clears at that edge. A write of 0x1B with bit 0 clear does not cancel it.
- R5: A `mac_tx_done` pulse sets bit 0 of the flag register at 0x31, and a `mac_rx_done` pulse sets bit 3. Both flags stay set until a read of 0x31.
- R6: A read of 0x31 returns the current flags and clears them at the same clock edge.
- R7: An event pulse that coincides with a read of 0x31 is not lost: its flag is set after that edge.
- R8: Bit 0 of address 0x24 takes the value of `mac_tx_retry_fail` at each `mac_tx_done` pulse. A `mac_tx_retry_fail` level without `mac_tx_done` has no effect.
- R9: Address 0x32 holds the mask bits 0 (transmit) and 3 (receive). A 1 disables the source. `irq_n` is 0 exactly when a flag is set and its mask bit is 0. The other bits of 0x32 read 0.
- R10: `irq_n` returns to 1 as soon as no unmasked flag remains set, whether a flag read cleared the flag or a mask write disabled the source.
- R11: Reads of unmapped addresses return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Short register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is 1, otherwise 0 |
| mac_tx_accept | input | 1 | MAC engine took the pending transmit request |
| mac_tx_done | input | 1 | MAC engine finished a transmit attempt |
| mac_tx_retry_fail | input | 1 | Qualifies mac_tx_done: the frame failed after the retry limit |
| mac_rx_done | input | 1 | MAC engine stored a received frame |
| tx_req | output | 1 | Transmit request to the MAC engine |
| tx_ack_req | output | 1 | Acknowledgement request for the triggered frame |
| irq_n | output | 1 | Level interrupt, active low |

## Verification
A stuck or wrongly cleared flag shows up on `irq_n` within one clock edge of the event or read, once its mask bit is 0. A flag that is masked shows only in the readback of 0x31. A lost coinciding event leaves 0x31 reading zero on the read that follows the clearing read. A trigger that drops early shows as `tx_req` falling before `mac_tx_accept`, on the edge after the fault. A wrong mask reset shows in the very first read of 0x32, and it also shows as an interrupt that fires on the first event after reset.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
  typedef logic [7:0] byte_t;

  localparam int EV_N = 2;

  localparam logic [7:0] ADR_TXCTL  = 8'h1B;
  localparam logic [7:0] ADR_TXSTS  = 8'h24;
  localparam logic [7:0] ADR_EVFLAG = 8'h31;
  localparam logic [7:0] ADR_EVMASK = 8'h32;

  localparam int BIT_TRIG = 0;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FAIL = 0;

  // Bit position in the flag and mask bytes of event source i (0: tx, 1: rx)
  function automatic int ev_pos(input int i);
    return (i == 0) ? 0 : 3;
  endfunction

  // Sticky flag update: a read clears, but a same-cycle event wins
  function automatic logic flag_next(input logic cur, input logic clr, input logic ev);
    return (cur & ~clr) | ev;
  endfunction

  // Spread the compact per-source bits into their byte positions
  function automatic byte_t spread(input logic [EV_N-1:0] v);
    byte_t b;
    b = '0;
    for (int i = 0; i < EV_N; i++) b[ev_pos(i)] = v[i];
    return b;
  endfunction

  // Interrupt pending when any flag is set with its mask bit at 0
  function automatic logic irq_pending(input logic [EV_N-1:0] fl, input logic [EV_N-1:0] mk);
    return |(fl & ~mk);
  endfunction

  function automatic byte_t ctl_byte(input logic trig, input logic ack);
    byte_t b;
    b = '0;
    b[BIT_TRIG] = trig;
    b[BIT_ACK]  = ack;
    return b;
  endfunction
endpackage

// File: rtl/tx_trigger_unit.sv
module tx_trigger_unit
  import radio_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctl,
  input  byte_t wdata,
  input  logic  tx_accept,
  input  logic  tx_done,
  input  logic  retry_fail,
  output logic  tx_req,
  output logic  ack_req,
  output byte_t ctl_rd,
  output byte_t sts_rd
);
  logic req_q, ack_q, fail_q;
  logic set_trig;

  assign set_trig = wr_ctl & wdata[BIT_TRIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (wr_ctl) ack_q <= wdata[BIT_ACK];
      if (set_trig) req_q <= 1'b1;
      else if (tx_accept) req_q <= 1'b0;
      if (tx_done) fail_q <= retry_fail;
    end
  end

  assign tx_req  = req_q;
  assign ack_req = ack_q;
  assign ctl_rd  = ctl_byte(req_q, ack_q);

  always_comb begin
    sts_rd = '0;
    sts_rd[BIT_FAIL] = fail_q;
  end
endmodule

// File: rtl/event_flag_unit.sv
module event_flag_unit
  import radio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [EV_N-1:0] ev,
  input  logic            mask_wr,
  input  byte_t           wdata,
  output byte_t           flag_rd,
  output byte_t           mask_rd,
  output logic            irq_n
);
  logic [EV_N-1:0] flag_q, mask_q;

  for (genvar g = 0; g < EV_N; g++) begin : g_src
    localparam int POS = ev_pos(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
        mask_q[g] <= 1'b1;
      end else begin
        flag_q[g] <= flag_next(flag_q[g], clr, ev[g]);
        if (mask_wr) mask_q[g] <= wdata[POS];
      end
    end
  end

  assign flag_rd = spread(flag_q);
  assign mask_rd = spread(mask_q);
  assign irq_n   = ~irq_pending(flag_q, mask_q);
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux
  import radio_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             ctl_rd,
  input  byte_t             sts_rd,
  input  byte_t             flag_rd,
  input  byte_t             mask_rd,
  output byte_t             rdata
);
  localparam int XW = (ADDR_W > 8) ? ADDR_W : 8;
  logic [XW-1:0] a;

  always_comb begin
    a = XW'(addr);
    rdata = '0;
    if (rd) begin
      if      (a == XW'(ADR_TXCTL))  rdata = ctl_rd;
      else if (a == XW'(ADR_TXSTS))  rdata = sts_rd;
      else if (a == XW'(ADR_EVFLAG)) rdata = flag_rd;
      else if (a == XW'(ADR_EVMASK)) rdata = mask_rd;
    end
  end
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
  import radio_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              mac_tx_accept,
  input  logic              mac_tx_done,
  input  logic              mac_tx_retry_fail,
  input  logic              mac_rx_done,
  output logic              tx_req,
  output logic              tx_ack_req,
  output logic              irq_n
);
  localparam int XW = (ADDR_W > 8) ? ADDR_W : 8;

  logic [XW-1:0] addr_x;
  logic wr_ctl, wr_mask, rd_clr;
  byte_t ctl_rd, sts_rd, flag_byte, mask_byte;
  logic [EV_N-1:0] ev_vec;

  assign addr_x  = XW'(reg_addr);
  assign wr_ctl  = reg_wr & (addr_x == XW'(ADR_TXCTL));
  assign wr_mask = reg_wr & (addr_x == XW'(ADR_EVMASK));
  assign rd_clr  = reg_rd & (addr_x == XW'(ADR_EVFLAG));
  assign ev_vec  = {mac_rx_done, mac_tx_done};

  tx_trigger_unit u_trig (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(reg_wdata),
    .tx_accept(mac_tx_accept), .tx_done(mac_tx_done), .retry_fail(mac_tx_retry_fail),
    .tx_req(tx_req), .ack_req(tx_ack_req), .ctl_rd(ctl_rd), .sts_rd(sts_rd)
  );

  event_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .clr(rd_clr), .ev(ev_vec),
    .mask_wr(wr_mask), .wdata(reg_wdata),
    .flag_rd(flag_byte), .mask_rd(mask_byte), .irq_n(irq_n)
  );

  reg_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .rd(reg_rd), .addr(reg_addr), .ctl_rd(ctl_rd), .sts_rd(sts_rd),
    .flag_rd(flag_byte), .mask_rd(mask_byte), .rdata(reg_rdata)
  );
endmodule

// File: rtl/radio_irq_chk.sv
module radio_irq_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              mac_tx_accept,
  input logic              mac_tx_done,
  input logic              mac_rx_done,
  input logic              tx_req,
  input logic              irq_n,
  input logic [7:0]        flag_byte,
  input logic [7:0]        mask_byte
);
  logic hit_ctl, hit_flag;
  assign hit_ctl  = (32'(reg_addr) == 32'h1B);
  assign hit_flag = (32'(reg_addr) == 32'h31);

  // R2
  trig_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && hit_ctl && reg_wdata[0] |=> tx_req);

  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !mac_tx_accept |=> tx_req);

  // R5
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_tx_done |=> flag_byte[0]);

  // R7
  rx_flag_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rx_done && reg_rd && hit_flag |=> flag_byte[3]);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_byte[0] && mask_byte[3] |-> irq_n);

  // R10
  read_releases_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && hit_flag && !mac_tx_done && !mac_rx_done && !reg_wr |=> irq_n);
endmodule

bind radio_irq_ctrl radio_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mac_tx_accept(mac_tx_accept), .mac_tx_done(mac_tx_done),
  .mac_rx_done(mac_rx_done), .tx_req(tx_req), .irq_n(irq_n),
  .flag_byte(flag_byte), .mask_byte(mask_byte)
);

// File: tb/test_radio_irq_ctrl.sv
module test_radio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic mac_tx_accept = 0, mac_tx_done = 0, mac_tx_retry_fail = 0, mac_rx_done = 0;
  logic tx_req, tx_ack_req, irq_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  radio_irq_ctrl i_radio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mac_tx_accept(mac_tx_accept),
    .mac_tx_done(mac_tx_done), .mac_tx_retry_fail(mac_tx_retry_fail),
    .mac_rx_done(mac_rx_done), .tx_req(tx_req), .tx_ack_req(tx_ack_req), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  // Read returns the value before the edge at which a clear takes effect
  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse(input logic tx, input logic fail, input logic rx);
    @(negedge clk); mac_tx_done = tx; mac_tx_retry_fail = fail; mac_rx_done = rx;
    @(negedge clk); mac_tx_done = 0; mac_tx_retry_fail = 0; mac_rx_done = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 tx_req", tx_req, 0); chk("R1 ack", tx_ack_req, 0); chk("R1 irq_n", irq_n, 1);
    rd(6'h1B, d); chk("R1 ctl", d, 8'h00);
    rd(6'h24, d); chk("R1 sts", d, 8'h00);
    rd(6'h31, d); chk("R1 flags", d, 8'h00);
    rd(6'h32, d); chk("R1 mask", d, 8'h09);
  endtask

  task automatic t_trigger;
    logic [7:0] d;
    wr(6'h1B, 8'h05);
    chk("R2 tx_req", tx_req, 1); chk("R3 ack", tx_ack_req, 1);
    rd(6'h1B, d); chk("R2 R3 ctl readback", d, 8'h05);
    wr(6'h1B, 8'h00);
    chk("R4 zero write keeps req", tx_req, 1); chk("R3 ack rewritten", tx_ack_req, 0);
    repeat (3) @(negedge clk);
    chk("R4 held without accept", tx_req, 1);
    mac_tx_accept = 1; @(negedge clk); mac_tx_accept = 0;
    chk("R4 cleared by accept", tx_req, 0);
    rd(6'h1B, d); chk("R4 ctl after accept", d, 8'h00);
  endtask

  task automatic t_sticky_and_clear;
    logic [7:0] d;
    pulse(1, 0, 0); pulse(0, 0, 1);
    repeat (2) @(negedge clk);
    rd(6'h31, d); chk("R5 both flags sticky", d, 8'h09);
    rd(6'h31, d); chk("R6 cleared by read", d, 8'h00);
    chk("R9 masked no irq", irq_n, 1);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    pulse(1, 0, 0);
    @(negedge clk); reg_rd = 1; reg_addr = 6'h31; mac_rx_done = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; mac_rx_done = 0;
    chk("R6 read value", d, 8'h01);
    rd(6'h31, d); chk("R7 coinciding rx kept", d, 8'h08);
    rd(6'h31, d); chk("R7 then cleared", d, 8'h00);
  endtask

  task automatic t_retry;
    logic [7:0] d;
    pulse(1, 1, 0);
    rd(6'h24, d); chk("R8 fail captured", d, 8'h01);
    @(negedge clk); mac_tx_retry_fail = 1; @(negedge clk); mac_tx_retry_fail = 0;
    pulse(0, 0, 0);
    rd(6'h24, d); chk("R8 fail alone no effect", d, 8'h01);
    pulse(1, 0, 0);
    rd(6'h24, d); chk("R8 success clears", d, 8'h00);
    rd(6'h31, d);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(6'h32, 8'hFF);
    rd(6'h32, d); chk("R9 mask other bits 0", d, 8'h09);
    pulse(1, 0, 0);
    chk("R9 tx masked", irq_n, 1);
    wr(6'h32, 8'h08);
    chk("R9 tx unmasked irq", irq_n, 0);
    wr(6'h32, 8'h09);
    chk("R10 mask releases irq", irq_n, 1);
    rd(6'h31, d); chk("R10 flag survives mask", d, 8'h01);
    wr(6'h32, 8'h00);
    pulse(0, 0, 1);
    chk("R9 rx irq", irq_n, 0);
    rd(6'h31, d); chk("R6 rx read", d, 8'h08);
    chk("R10 read releases irq", irq_n, 1);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(6'h10, 8'hFF); wr(6'h33, 8'hFF);
    rd(6'h10, d); chk("R11 unmapped read", d, 8'h00);
    rd(6'h32, d); chk("R11 mask untouched", d, 8'h00);
    rd(6'h1B, d); chk("R11 ctl untouched", d, 8'h00);
    chk("R11 no trigger", tx_req, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_trigger();
    t_sticky_and_clear();
    t_coincide();
    t_retry();
    t_mask();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule